// File: doc/BRIEF.md
# 8080-Style Parallel Display Write Master

This block drives a write-only parallel bus toward a display controller. The bus has an active-low chip select, an active-low write strobe, an active-low read strobe, a command/data select line and a 16-bit data bus. The bus protocol follows the common 8080 style. The block has two feed paths that share one bus-cycle engine.

The first path is a register port. Each accepted write becomes exactly one bus cycle, either a command cycle or a data cycle. Software uses it to send a panel's initialisation sequence.

The second path is a frame-buffer stream. When the stream-enable input is set, 32-bit words arrive on a valid/ready interface. Each word goes out as two 16-bit data cycles, and the register path is locked out.

Every bus cycle has three phases: setup, strobe and hold. Each phase lasts a programmed number of ticks. A tick is one period of an internal clock, which is the functional clock divided by an 8-bit divisor.

Top module: `dbus8080_writer`

## Requirements
- R1: With `stream_en` low, a register write accepted with `reg_sel`=0 produces exactly one bus cycle. In that cycle `bus_cd` is 0 and `bus_data` equals `reg_wdata`.
- R2: With `stream_en` low, a register write accepted with `reg_sel`=1 produces exactly one bus cycle. In that cycle `bus_cd` is 1 and `bus_data` equals `reg_wdata`.
- R3: `bus_cs_n` is low for the whole of each bus cycle and returns high for at least one clock between cycles. `bus_we_n` is low only while `bus_cs_n` is low. `bus_re_n` stays high at all times.
- R4: Let D = max(`cfg_div`,1) and let S, W, H be `cfg_setup`, `cfg_strobe` and `cfg_hold`, each with 0 treated as 1. A cycle has chip select low with the strobe high for S·D clocks, then the strobe low for W·D clocks, then chip select low with the strobe high for H·D clocks.
- R5: `busy` is high from the clock after a write is accepted until its hold phase ends. While `stream_en` is low and `busy` is high, `reg_ready` is low. A write held during that time is stalled and is sent afterwards, not lost.
- R6: While `stream_en` is high, `reg_ready` is high, and register writes are consumed without producing any bus cycle.
- R7: Each accepted stream word produces two bus cycles with `bus_cd`=1. Bits [15:0] are sent first, then bits [31:16].
- R8: `s_ready` is high only when `stream_en` is high, no bus cycle is in progress and no upper halfword is still waiting to be sent.
- R9: If `stream_en` falls after a word is accepted, both halfwords of that word are still sent before the block goes idle.
- R10: While `rst` is high, and after it is released, `bus_cs_n`, `bus_we_n` and `bus_re_n` are 1, `bus_data` is 0 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | 8 | Tick divisor (0 acts as 1) |
| cfg_setup | input | 4 | Setup phase length in ticks (0 acts as 1) |
| cfg_strobe | input | 4 | Strobe phase length in ticks (0 acts as 1) |
| cfg_hold | input | 4 | Hold phase length in ticks (0 acts as 1) |
| stream_en | input | 1 | Selects streaming mode |
| reg_wr | input | 1 | Register write request |
| reg_sel | input | 1 | 0 selects a command cycle, 1 selects a data cycle |
| reg_wdata | input | 16 | Register write value |
| reg_ready | output | 1 | Register write accepted when high |
| busy | output | 1 | A bus cycle or a pending halfword is in progress |
| s_valid | input | 1 | Stream word valid |
| s_data | input | 32 | Stream word |
| s_ready | output | 1 | Stream word accepted when high |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_re_n | output | 1 | Read strobe, active low, held inactive |
| bus_cd | output | 1 | Command/data select: 0 for command, 1 for data |
| bus_data | output | 16 | Bus data |

## Verification
The bench builds the block with its default parameters: a 16-bit bus, an 8-bit divisor and 4-bit phase fields. With these, the full range of each phase field, including 0 and 15, can be reached cheaply. A divisor of 0, 1 or 3 keeps cycles short while still showing that every phase length scales with the divisor. A monitor measures each phase in clocks, so the mid-word disable and the stall paths can be checked against exact halfword values and orderings.

// File: rtl/dbw_pkg.sv
`timescale 1ns/1ps
package dbw_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_t;
endpackage

// File: rtl/dbw_tick_gen.sv
`timescale 1ns/1ps
module dbw_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  // a divisor of zero behaves like one
  assign lim  = (divisor == '0) ? '0 : divisor - DIV_W'(1);
  assign tick = (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || clr || tick) cnt <= '0;
    else                    cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/dbw_phase_engine.sv
`timescale 1ns/1ps
module dbw_phase_engine
  import dbw_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int TIME_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BUS_W-1:0]  st_data,
  input  logic              st_cd,
  input  logic              tick,
  input  logic [TIME_W-1:0] cfg_setup,
  input  logic [TIME_W-1:0] cfg_strobe,
  input  logic [TIME_W-1:0] cfg_hold,
  output logic              idle,
  output logic              cs_n,
  output logic              we_n,
  output logic              cd,
  output logic [BUS_W-1:0]  data
);
  phase_t            state;
  logic [TIME_W-1:0] pc;
  logic [TIME_W-1:0] n_su, n_st, n_ho;
  logic [TIME_W-1:0] cur_n;
  logic              last;

  always_comb begin
    case (state)
      PH_SETUP:  cur_n = n_su;
      PH_STROBE: cur_n = n_st;
      PH_HOLD:   cur_n = n_ho;
      default:   cur_n = TIME_W'(1);
    endcase
  end

  assign last = tick && (pc == cur_n - TIME_W'(1));
  assign idle = (state == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PH_IDLE;
      pc    <= '0;
      n_su  <= TIME_W'(1);
      n_st  <= TIME_W'(1);
      n_ho  <= TIME_W'(1);
      cs_n  <= 1'b1;
      we_n  <= 1'b1;
      cd    <= 1'b0;
      data  <= '0;
    end else begin
      case (state)
        PH_IDLE: begin
          if (start) begin
            state <= PH_SETUP;
            pc    <= '0;
            cs_n  <= 1'b0;
            data  <= st_data;
            cd    <= st_cd;
            n_su  <= (cfg_setup  == '0) ? TIME_W'(1) : cfg_setup;
            n_st  <= (cfg_strobe == '0) ? TIME_W'(1) : cfg_strobe;
            n_ho  <= (cfg_hold   == '0) ? TIME_W'(1) : cfg_hold;
          end
        end
        default: begin
          if (last) begin
            pc <= '0;
            case (state)
              PH_SETUP: begin
                state <= PH_STROBE;
                we_n  <= 1'b0;
              end
              PH_STROBE: begin
                state <= PH_HOLD;
                we_n  <= 1'b1;
              end
              default: begin
                state <= PH_IDLE;
                cs_n  <= 1'b1;
              end
            endcase
          end else if (tick) begin
            pc <= pc + TIME_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dbw_feed.sv
`timescale 1ns/1ps
module dbw_feed #(
  parameter int BUS_W = 16,
  localparam int WORD_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stream_en,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [BUS_W-1:0]  reg_wdata,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_data,
  input  logic              eng_idle,
  output logic              reg_ready,
  output logic              s_ready,
  output logic              busy,
  output logic              start,
  output logic [BUS_W-1:0]  st_data,
  output logic              st_cd
);
  logic             half_pend;
  logic [BUS_W-1:0] upper;
  logic             free, take_s, take_r, take_h;

  assign free      = eng_idle && !half_pend;
  assign s_ready   = stream_en && free;
  assign reg_ready = stream_en || free;   // writes in streaming mode are swallowed
  assign take_s    = s_valid && s_ready;
  assign take_r    = reg_wr && !stream_en && free;
  assign take_h    = eng_idle && half_pend;
  assign start     = take_h || take_s || take_r;
  assign busy      = !eng_idle || half_pend;

  always_comb begin
    if (take_h) begin
      st_data = upper;
      st_cd   = 1'b1;
    end else if (take_s) begin
      st_data = s_data[BUS_W-1:0];
      st_cd   = 1'b1;
    end else begin
      st_data = reg_wdata;
      st_cd   = reg_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_pend <= 1'b0;
      upper     <= '0;
    end else if (take_s) begin
      half_pend <= 1'b1;
      upper     <= s_data[WORD_W-1:BUS_W];
    end else if (take_h) begin
      half_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/dbus8080_writer.sv
`timescale 1ns/1ps
module dbus8080_writer #(
  parameter int BUS_W  = 16,
  parameter int DIV_W  = 8,
  parameter int TIME_W = 4,
  localparam int WORD_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [TIME_W-1:0] cfg_setup,
  input  logic [TIME_W-1:0] cfg_strobe,
  input  logic [TIME_W-1:0] cfg_hold,
  input  logic              stream_en,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic              reg_ready,
  output logic              busy,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_data,
  output logic              s_ready,
  output logic              bus_cs_n,
  output logic              bus_we_n,
  output logic              bus_re_n,
  output logic              bus_cd,
  output logic [BUS_W-1:0]  bus_data
);
  logic             eng_idle, start, st_cd, tick;
  logic [BUS_W-1:0] st_data;

  assign bus_re_n = 1'b1;

  dbw_feed #(.BUS_W(BUS_W)) u_feed (
    .clk(clk), .rst(rst), .stream_en(stream_en),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .s_valid(s_valid), .s_data(s_data), .eng_idle(eng_idle),
    .reg_ready(reg_ready), .s_ready(s_ready), .busy(busy),
    .start(start), .st_data(st_data), .st_cd(st_cd)
  );

  dbw_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .clr(start), .divisor(cfg_div), .tick(tick)
  );

  dbw_phase_engine #(.BUS_W(BUS_W), .TIME_W(TIME_W)) u_eng (
    .clk(clk), .rst(rst), .start(start), .st_data(st_data), .st_cd(st_cd),
    .tick(tick), .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe),
    .cfg_hold(cfg_hold), .idle(eng_idle), .cs_n(bus_cs_n), .we_n(bus_we_n),
    .cd(bus_cd), .data(bus_data)
  );
endmodule

// File: rtl/dbw_checker.sv
`timescale 1ns/1ps
module dbw_checker #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             stream_en,
  input logic             reg_ready,
  input logic             busy,
  input logic             s_ready,
  input logic             bus_cs_n,
  input logic             bus_we_n,
  input logic             bus_re_n,
  input logic             bus_cd,
  input logic [BUS_W-1:0] bus_data
);
  // R3: strobe only inside chip select
  a_r3_strobe_in_cs: assert property (@(posedge clk) disable iff (rst)
    !bus_we_n |-> !bus_cs_n);

  // R3: read strobe never asserted
  a_r3_read_idle: assert property (@(posedge clk) disable iff (rst)
    bus_re_n);

  // R1, R2: data and select held steady through a cycle
  a_r1_bus_stable: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && $past(!bus_cs_n)) |-> ($stable(bus_data) && $stable(bus_cd)));

  // R5: register port stalls while busy outside streaming
  a_r5_stall_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && !stream_en) |-> !reg_ready);

  // R8: stream ready only with the bus at rest
  a_r8_ready_idle: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> (bus_cs_n && !busy && stream_en));

  // R6: register port open in streaming mode
  a_r6_swallow: assert property (@(posedge clk) disable iff (rst)
    stream_en |-> reg_ready);
endmodule

bind dbus8080_writer dbw_checker #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .stream_en(stream_en), .reg_ready(reg_ready),
  .busy(busy), .s_ready(s_ready), .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n),
  .bus_re_n(bus_re_n), .bus_cd(bus_cd), .bus_data(bus_data)
);

// File: tb/dbus8080_writer_bench.sv
`timescale 1ns/1ps
module dbus8080_writer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_div = 8'd1;
  logic [3:0]  cfg_setup = 4'd1, cfg_strobe = 4'd1, cfg_hold = 4'd1;
  logic        stream_en = 1'b0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic        reg_ready, busy;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready;
  logic        bus_cs_n, bus_we_n, bus_re_n, bus_cd;
  logic [15:0] bus_data;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dbus8080_writer u_dbus8080_writer (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_setup(cfg_setup),
    .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold), .stream_en(stream_en),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_ready(reg_ready), .busy(busy), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n),
    .bus_re_n(bus_re_n), .bus_cd(bus_cd), .bus_data(bus_data)
  );

  // bus monitor, sampled away from the active edge
  int          n_tx = 0, re_low = 0, gap = 0;
  bit          in_tx = 0, seen = 0;
  int          su, st, ho, gap_now;
  logic [15:0] cap_d;
  logic        cap_cd;
  int          t_su[32], t_st[32], t_ho[32], t_gap[32];
  logic [15:0] t_d[32];
  logic        t_cd[32];

  always @(negedge clk) begin
    if (!rst) begin
      if (!bus_re_n) re_low++;
      if (!bus_cs_n) begin
        if (!in_tx) begin
          in_tx = 1; seen = 0; su = 0; st = 0; ho = 0; gap_now = gap;
        end
        if (!bus_we_n) begin
          st++; seen = 1; cap_d = bus_data; cap_cd = bus_cd;
        end else if (seen) ho++;
        else su++;
      end else begin
        if (in_tx) begin
          if (n_tx < 32) begin
            t_su[n_tx] = su; t_st[n_tx] = st; t_ho[n_tx] = ho;
            t_d[n_tx] = cap_d; t_cd[n_tx] = cap_cd; t_gap[n_tx] = gap_now;
          end
          n_tx++; in_tx = 0; gap = 0;
        end
        gap++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    while (!reg_ready) @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic push_word(input logic [31:0] w);
    @(negedge clk);
    s_valid = 1'b1; s_data = w;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      if (!busy && bus_cs_n && !in_tx) quiet++; else quiet = 0;
    end
  endtask

  task automatic check_tx(input int i, input string tag, input logic [15:0] d,
                          input logic c);
    check(t_d[i] == d, {tag, " data"}, t_d[i], d);
    check(t_cd[i] == c, {tag, " cd"}, t_cd[i], c);
  endtask

  task automatic check_times(input int i, input string tag, input int es,
                             input int ew, input int eh);
    check(t_su[i] == es, {tag, " setup"}, t_su[i], es);
    check(t_st[i] == ew, {tag, " strobe"}, t_st[i], ew);
    check(t_ho[i] == eh, {tag, " hold"}, t_ho[i], eh);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(bus_cs_n && bus_we_n && bus_re_n, "R10 strobes idle in reset", {bus_cs_n, bus_we_n, bus_re_n}, 7);
    check(bus_data == 16'h0, "R10 data zero", bus_data, 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && bus_cs_n && !s_ready, "R10 idle after reset", {busy, bus_cs_n, s_ready}, 2);
  endtask

  task automatic t_cmd_and_data();
    int b = n_tx;
    cfg_div = 8'd1; cfg_setup = 4'd2; cfg_strobe = 4'd3; cfg_hold = 4'd1;
    reg_write(1'b0, 16'h0011);
    wait_idle();
    check(n_tx == b + 1, "R1 one cycle per command", n_tx - b, 1);
    check_tx(b, "R1", 16'h0011, 1'b0);
    reg_write(1'b1, 16'hA5C3);
    wait_idle();
    check(n_tx == b + 2, "R2 one cycle per data write", n_tx - b, 2);
    check_tx(b + 1, "R2", 16'hA5C3, 1'b1);
    check_times(b + 1, "R4 div1", 2, 3, 1);
  endtask

  task automatic t_timing();
    int b = n_tx;
    cfg_div = 8'd3; cfg_setup = 4'd2; cfg_strobe = 4'd5; cfg_hold = 4'd1;
    reg_write(1'b1, 16'h1234);
    wait_idle();
    check_times(b, "R4 div3", 6, 15, 3);
    cfg_div = 8'd0; cfg_setup = 4'd0; cfg_strobe = 4'd0; cfg_hold = 4'd0;
    reg_write(1'b0, 16'h00F0);
    wait_idle();
    check_times(b + 1, "R4 zeros", 1, 1, 1);
    cfg_div = 8'd1; cfg_setup = 4'd15; cfg_strobe = 4'd15; cfg_hold = 4'd15;
    reg_write(1'b1, 16'h8001);
    wait_idle();
    check_times(b + 2, "R4 max fields", 15, 15, 15);
  endtask

  task automatic t_stall();
    int b = n_tx;
    int stalled = 0;
    cfg_div = 8'd2; cfg_setup = 4'd1; cfg_strobe = 4'd2; cfg_hold = 4'd1;
    reg_write(1'b0, 16'h002A);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 16'h0055;
    check(busy, "R5 busy during cycle", busy, 1);
    while (!reg_ready) begin stalled++; @(negedge clk); end
    @(negedge clk);
    reg_wr = 1'b0;
    wait_idle();
    check(stalled > 0, "R5 second write stalled", stalled, 1);
    check(n_tx == b + 2, "R5 stalled write not dropped", n_tx - b, 2);
    check_tx(b + 1, "R5", 16'h0055, 1'b1);
    check(t_gap[b + 1] >= 1, "R3 chip select released between", t_gap[b + 1], 1);
  endtask

  task automatic t_stream();
    int b = n_tx;
    cfg_div = 8'd1; cfg_setup = 4'd1; cfg_strobe = 4'd1; cfg_hold = 4'd1;
    @(negedge clk);
    stream_en = 1'b1;
    @(negedge clk);
    check(s_ready, "R8 ready when streaming and idle", s_ready, 1);
    push_word(32'hBEEF_1234);
    check(!s_ready, "R8 not ready with half pending", s_ready, 0);
    push_word(32'h0F0F_A0A0);
    wait_idle();
    check(n_tx == b + 4, "R7 two cycles per word", n_tx - b, 4);
    check_tx(b,     "R7 w0 lo", 16'h1234, 1'b1);
    check_tx(b + 1, "R7 w0 hi", 16'hBEEF, 1'b1);
    check_tx(b + 2, "R7 w1 lo", 16'hA0A0, 1'b1);
    check_tx(b + 3, "R7 w1 hi", 16'h0F0F, 1'b1);
    b = n_tx;
    @(negedge clk);
    check(reg_ready, "R6 register port open", reg_ready, 1);
    reg_write(1'b0, 16'h00FF);
    repeat (40) @(negedge clk);
    check(n_tx == b && bus_cs_n, "R6 swallowed write gives no cycle", n_tx - b, 0);
  endtask

  task automatic t_disable_mid();
    int b = n_tx;
    cfg_div = 8'd2; cfg_setup = 4'd2; cfg_strobe = 4'd2; cfg_hold = 4'd2;
    push_word(32'hCAFE_5A5A);
    stream_en = 1'b0;
    check(!s_ready, "R8 not ready after disable", s_ready, 0);
    wait_idle();
    check(n_tx == b + 2, "R9 both halves finish", n_tx - b, 2);
    check_tx(b,     "R9 lo", 16'h5A5A, 1'b1);
    check_tx(b + 1, "R9 hi", 16'hCAFE, 1'b1);
    check(re_low == 0, "R3 read strobe never low", re_low, 0);
  endtask

  initial begin
    t_reset();
    t_cmd_and_data();
    t_timing();
    t_stall();
    t_stream();
    t_disable_mid();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule